// File: doc/BRIEF.md
# ATA PIO and Multiword DMA Cycle Engine

This block sequences single data-word transfers on one ATA/IDE channel from the host side. A host issues a request that carries a direction, a mode (programmed I/O or multiword DMA), a device-select pattern and, for writes, a 16-bit word. The engine then drives the channel's read or write strobe, the chip selects or the DMA acknowledge, and the data bus enable. It signals completion with a one-clock done pulse. Read data and an error flag are valid in that same clock.

Every cycle has three phases: setup, strobe-active and recovery. Each phase lasts a number of clocks taken from a configuration input. In PIO mode the device can stretch the active phase by holding its ready line low, and a programmable limit bounds the stretch. In DMA mode no cycle begins until the device raises its DMA request. The acknowledge then stays asserted across back-to-back words for as long as that request persists.

The device-side inputs are assumed to be synchronous to `clk`. The asynchronous active-low reset is synchronised inside the block, so the engine leaves reset two clocks after `rst_n` rises.

Top module: `ata_cycle_engine`

## Requirements
- R1: After a request is accepted (`req_valid` high while `req_ready` is high), the strobe asserts after max(`cfg_setup`,1) clocks of setup. A value of 0 in any timing field counts as 1.
- R2: Without wait states, the strobe (`dior_n` for reads, `diow_n` for writes, both active low) stays low for exactly max(`cfg_active`,1) clocks, and the two strobes are never low together.
- R3: After the strobe rises, recovery lasts max(`cfg_recov`,1) clocks. Then `done` pulses high for exactly one clock.
- R4: On a read, `rd_data` holds the value of `dd_in` from the last clock in which `dior_n` was low, and it is valid while `done` is high.
- R5: On a write, `dd_oe` is high from the first setup clock through one clock after `diow_n` rises, and `dd_out` equals the requested word throughout. On a read, `dd_oe` stays low.
- R6: In a PIO cycle, `cs_n` equals the bitwise inverse of `req_sel` from setup through recovery, and `dack_n` stays high. In a DMA cycle, `cs_n` stays 2'b11. Whenever a strobe is low, exactly one of chip select and acknowledge is active.
- R7: In PIO mode, if `iordy` is low when the programmed active time ends, the strobe stays low until the clock in which `iordy` is sampled high.
- R8: If `iordy` stays low, the active phase ends after max(`cfg_active`,1)+`cfg_timeout` clocks, and `err` is high during the done pulse. A cycle that ends normally reports `err` low.
- R9: A DMA request accepted while `dmarq` is low asserts neither `dack_n` nor a strobe until `dmarq` goes high.
- R10: `dack_n` goes low at the start of DMA setup. If `dmarq` is high at the end of recovery, `dack_n` stays low and a further DMA request is accepted directly. If `dmarq` is low at that point, `dack_n` rises with the done pulse. If `dmarq` falls while the engine is parked, `dack_n` rises one clock later.
- R11: In DMA mode, `iordy` has no effect on the active phase length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request strobe |
| req_write | input | 1 | 1 = write to device, 0 = read |
| req_dma | input | 1 | 1 = multiword DMA cycle, 0 = PIO cycle |
| req_sel | input | 2 | PIO device select pattern (active high) |
| req_wdata | input | 16 | Write word |
| req_ready | output | 1 | Request can be accepted this clock |
| done | output | 1 | One-clock completion pulse |
| err | output | 1 | Ready-timeout flag, valid with done |
| rd_data | output | 16 | Captured read word, valid with done |
| cfg_setup | input | 4 | Setup time in clocks |
| cfg_active | input | 4 | Strobe-active time in clocks |
| cfg_recov | input | 4 | Recovery time in clocks |
| cfg_timeout | input | 8 | Maximum wait-state clocks |
| dd_out | output | 16 | Data bus output value |
| dd_oe | output | 1 | Data bus output enable |
| dd_in | input | 16 | Data bus input value |
| dior_n | output | 1 | Read strobe, active low |
| diow_n | output | 1 | Write strobe, active low |
| cs_n | output | 2 | Chip selects, active low |
| dack_n | output | 1 | DMA acknowledge, active low |
| iordy | input | 1 | Channel ready from device |
| dmarq | input | 1 | DMA request from device |

## Verification
The assertions take for granted that `iordy` and `dmarq` are already synchronous to `clk`, and that the configuration inputs stay constant while a cycle runs. The stimulus changes the timing fields only between cycles, and it drives every device-side input at the falling clock edge. It also moves `dmarq` only when the engine is idle or parked, or during recovery when it tests acknowledge release, so that the acknowledge checks see a well-defined request level at each decision edge.

// File: rtl/ata_cyc_pkg.sv
package ata_cyc_pkg;
  localparam int SEL_W = 2;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WAITRQ = 3'd1,
    ST_SETUP  = 3'd2,
    ST_ACTIVE = 3'd3,
    ST_RECOV  = 3'd4,
    ST_PARK   = 3'd5
  } cyc_state_t;
endpackage

// File: rtl/ata_phase_timer.sv
module ata_phase_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);
  logic [W-1:0] cnt_q, cnt_d;

  // phase length is max(load_val,1): load val-1, finish when zero
  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = (load_val == '0) ? '0 : load_val - 1'b1;
    else if (dec && cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/ata_wait_timer.sv
module ata_wait_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  input  logic [W-1:0] limit,
  output logic         expired
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                     cnt_d = '0;
    else if (inc && !expired)    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == limit);

  // R8: the wait counter is only advanced below its limit
  a_r8_wait_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && !expired) |=> (cnt_q != '0));
endmodule

// File: rtl/ata_cycle_engine.sv
module ata_cycle_engine
  import ata_cyc_pkg::*;
#(
  parameter int DW    = 16,
  parameter int CNT_W = 4,
  parameter int TO_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             req_dma,
  input  logic [SEL_W-1:0] req_sel,
  input  logic [DW-1:0]    req_wdata,
  output logic             req_ready,
  output logic             done,
  output logic             err,
  output logic [DW-1:0]    rd_data,
  input  logic [CNT_W-1:0] cfg_setup,
  input  logic [CNT_W-1:0] cfg_active,
  input  logic [CNT_W-1:0] cfg_recov,
  input  logic [TO_W-1:0]  cfg_timeout,
  output logic [DW-1:0]    dd_out,
  output logic             dd_oe,
  input  logic [DW-1:0]    dd_in,
  output logic             dior_n,
  output logic             diow_n,
  output logic [SEL_W-1:0] cs_n,
  output logic             dack_n,
  input  logic             iordy,
  input  logic             dmarq
);
  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  cyc_state_t st_q, st_d;
  logic             wr_q, dma_q, err_q, done_q, hold_q;
  logic [SEL_W-1:0] sel_q;
  logic [DW-1:0]    wdata_q, rd_q;

  logic             tm_load, tm_zero, tm_dec;
  logic [CNT_W-1:0] tm_val;
  logic             wt_clr, wt_inc, wt_exp;
  logic             accept, act_end, to_hit, fin;
  logic             in_cycle;

  ata_phase_timer #(.W(CNT_W)) u_phase (
    .clk(clk), .rst_n(rst_s), .load(tm_load), .load_val(tm_val),
    .dec(tm_dec), .zero(tm_zero));

  ata_wait_timer #(.W(TO_W)) u_wait (
    .clk(clk), .rst_n(rst_s), .clr(wt_clr), .inc(wt_inc),
    .limit(cfg_timeout), .expired(wt_exp));

  assign in_cycle = (st_q == ST_SETUP) || (st_q == ST_ACTIVE) || (st_q == ST_RECOV);
  assign tm_dec   = in_cycle && !tm_load;
  assign req_ready = (st_q == ST_IDLE) ||
                     ((st_q == ST_PARK) && req_dma && dmarq);

  // next-state logic
  always_comb begin
    st_d    = st_q;
    tm_load = 1'b0;
    tm_val  = cfg_setup;
    wt_clr  = 1'b0;
    wt_inc  = 1'b0;
    accept  = 1'b0;
    act_end = 1'b0;
    to_hit  = 1'b0;
    fin     = 1'b0;
    unique case (st_q)
      ST_IDLE: if (req_valid) begin
        accept = 1'b1;
        if (req_dma && !dmarq) st_d = ST_WAITRQ;
        else begin st_d = ST_SETUP; tm_load = 1'b1; end
      end
      ST_WAITRQ: if (dmarq) begin
        st_d = ST_SETUP; tm_load = 1'b1;
      end
      ST_SETUP: if (tm_zero) begin
        st_d = ST_ACTIVE; tm_load = 1'b1; tm_val = cfg_active; wt_clr = 1'b1;
      end
      ST_ACTIVE: if (tm_zero) begin
        if (dma_q || iordy) act_end = 1'b1;
        else if (wt_exp) begin act_end = 1'b1; to_hit = 1'b1; end
        else wt_inc = 1'b1;
        if (act_end) begin
          st_d = ST_RECOV; tm_load = 1'b1; tm_val = cfg_recov;
        end
      end
      ST_RECOV: if (tm_zero) begin
        fin  = 1'b1;
        st_d = (dma_q && dmarq) ? ST_PARK : ST_IDLE;
      end
      ST_PARK: begin
        if (!dmarq) st_d = ST_IDLE;
        else if (req_valid && req_dma) begin
          accept = 1'b1; st_d = ST_SETUP; tm_load = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      st_q    <= ST_IDLE;
      wr_q    <= 1'b0;
      dma_q   <= 1'b0;
      sel_q   <= '0;
      wdata_q <= '0;
      rd_q    <= '0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
      hold_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= fin;
      hold_q <= act_end && wr_q;
      if (accept) begin
        wr_q    <= req_write;
        dma_q   <= req_dma;
        sel_q   <= req_sel;
        wdata_q <= req_wdata;
      end
      if (act_end && !wr_q) rd_q <= dd_in;
      if (accept)      err_q <= 1'b0;
      else if (to_hit) err_q <= 1'b1;
    end
  end

  // device-side decode from registered state
  assign dior_n  = !((st_q == ST_ACTIVE) && !wr_q);
  assign diow_n  = !((st_q == ST_ACTIVE) && wr_q);
  assign cs_n    = (in_cycle && !dma_q) ? ~sel_q : {SEL_W{1'b1}};
  assign dack_n  = !(dma_q && (in_cycle || st_q == ST_PARK));
  assign dd_oe   = (wr_q && ((st_q == ST_SETUP) || (st_q == ST_ACTIVE))) || hold_q;
  assign dd_out  = wdata_q;
  assign done    = done_q;
  assign err     = err_q;
  assign rd_data = rd_q;

  // R2: never both strobes low
  a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_s)
    !(!dior_n && !diow_n));
  // R5: no bus drive while the device may drive
  a_r5_no_oe_on_read: assert property (@(posedge clk) disable iff (!rst_s)
    !dior_n |-> !dd_oe);
  // R9: acknowledge only follows a device request
  a_r9_dack_needs_rq: assert property (@(posedge clk) disable iff (!rst_s)
    $fell(dack_n) |-> $past(dmarq));
  // R3: done is a single-clock pulse
  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_s)
    done |=> !done);
  // R10: acknowledge released when request drops while parked
  a_r10_park_release: assert property (@(posedge clk) disable iff (!rst_s)
    (st_q == ST_PARK && !dmarq) |=> dack_n);
  // R6: exactly one target qualifier during a strobe
  a_r6_one_target: assert property (@(posedge clk) disable iff (!rst_s)
    (!dior_n || !diow_n) |-> ((cs_n != {SEL_W{1'b1}}) != !dack_n));
endmodule

// File: tb/ata_cycle_engine_tb.sv
module ata_cycle_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_dma = 1'b0;
  logic [1:0]  req_sel = 2'b00;
  logic [15:0] req_wdata = '0;
  logic        req_ready, done, err;
  logic [15:0] rd_data;
  logic [3:0]  cfg_setup = 4'd1, cfg_active = 4'd1, cfg_recov = 4'd1;
  logic [7:0]  cfg_timeout = 8'd4;
  logic [15:0] dd_out, dd_in = '0;
  logic        dd_oe, dior_n, diow_n, dack_n;
  logic [1:0]  cs_n;
  logic        iordy = 1'b1, dmarq = 1'b0;

  int checks = 0, fails = 0, cycles = 0;
  // monitor results
  int m_pre, m_act, m_post, m_oe, m_bad_sel, m_bad_data;
  logic m_err;
  logic [15:0] m_rd;

  always #10 clk = ~clk;  // 50 MHz

  ata_cycle_engine dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_dma(req_dma), .req_sel(req_sel), .req_wdata(req_wdata),
    .req_ready(req_ready), .done(done), .err(err), .rd_data(rd_data),
    .cfg_setup(cfg_setup), .cfg_active(cfg_active), .cfg_recov(cfg_recov),
    .cfg_timeout(cfg_timeout), .dd_out(dd_out), .dd_oe(dd_oe), .dd_in(dd_in),
    .dior_n(dior_n), .diow_n(diow_n), .cs_n(cs_n), .dack_n(dack_n),
    .iordy(iordy), .dmarq(dmarq));

  function automatic int eff(input logic [3:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  // present request at a falling edge, leave at the next falling edge
  task automatic issue(input bit wr, input bit dma, input logic [1:0] sel, input logic [15:0] wd);
    req_write = wr; req_dma = dma; req_sel = sel; req_wdata = wd; req_valid = 1'b1;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // entered at a falling edge in the first setup clock; returns at the done clock
  // stretch_w >= 0 raises iordy after A+stretch_w active clocks
  task automatic monitor(input bit wr, input bit dma, input logic [1:0] sel,
                         input logic [15:0] wd, input logic [15:0] base,
                         input int a_eff, input int stretch_w, input bit drop_rq);
    int guard = 0;
    m_pre = 0; m_act = 0; m_post = 0; m_oe = 0; m_bad_sel = 0; m_bad_data = 0;
    while (!done && guard < 2000) begin
      guard++;
      if (dd_oe) begin m_oe++; if (dd_out !== wd) m_bad_data++; end
      if (dma) begin if (cs_n !== 2'b11 || dack_n !== 1'b0) m_bad_sel++; end
      else if (cs_n !== ~sel || dack_n !== 1'b1) m_bad_sel++;
      if ((wr ? diow_n : dior_n) == 1'b0) begin
        m_act++;
        dd_in = base + 16'(m_act);
        if (stretch_w >= 0 && m_act == a_eff + stretch_w) iordy = 1'b1;
      end else if (m_act == 0) m_pre++;
      else begin
        m_post++;
        if (drop_rq && m_post == 1) dmarq = 1'b0;
      end
      @(negedge clk);
    end
    m_err = err;
    m_rd = rd_data;
  endtask

  task automatic run(input bit wr, input bit dma, input logic [1:0] sel,
                     input logic [15:0] wd, input int stretch_w, input bit drop_rq,
                     input bit exp_err, input int exp_act);
    logic [15:0] base = 16'($urandom);
    issue(wr, dma, sel, wd);
    monitor(wr, dma, sel, wd, base, eff(cfg_active), stretch_w, drop_rq);
    check(m_pre == eff(cfg_setup), "R1 setup clocks", m_pre, eff(cfg_setup));
    check(m_act == exp_act, "R2/R7/R8/R11 active clocks", m_act, exp_act);
    check(m_post == eff(cfg_recov), "R3 recovery clocks", m_post, eff(cfg_recov));
    check(m_err == exp_err, "R8 err flag", int'(m_err), int'(exp_err));
    check(m_bad_sel == 0, "R6 select/ack pattern", m_bad_sel, 0);
    if (wr) begin
      check(m_oe == eff(cfg_setup) + exp_act + 1, "R5 oe span", m_oe,
            eff(cfg_setup) + exp_act + 1);
      check(m_bad_data == 0, "R5 write data", m_bad_data, 0);
    end else begin
      check(m_oe == 0, "R5 oe on read", m_oe, 0);
      check(m_rd == base + 16'(exp_act), "R4 read capture", int'(m_rd),
            int'(base + 16'(exp_act)));
    end
    @(negedge clk);
    check(done == 1'b0, "R3 done width", int'(done), 0);
  endtask

  task automatic set_times(input int s, input int a, input int r);
    cfg_setup = 4'(s); cfg_active = 4'(a); cfg_recov = 4'(r);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // reset state
    check(dior_n && diow_n, "R2 strobes idle in reset", int'({dior_n, diow_n}), 3);
    check(dack_n === 1'b1 && cs_n === 2'b11, "R6 selects idle in reset",
          int'({dack_n, cs_n}), 7);
    check(dd_oe === 1'b0 && done === 1'b0, "R5 oe/done low in reset",
          int'({dd_oe, done}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(req_ready === 1'b1, "R1 ready after reset", int'(req_ready), 1);

    // directed: minimum values and zero fields
    set_times(0, 0, 0);
    run(1'b0, 1'b0, 2'b01, 16'h1111, -1, 1'b0, 1'b0, 1);
    set_times(3, 5, 2);
    run(1'b1, 1'b0, 2'b10, 16'hA5C3, -1, 1'b0, 1'b0, 5);

    // R7: wait states within the limit
    cfg_timeout = 8'd6;
    iordy = 1'b0;
    run(1'b0, 1'b0, 2'b01, 16'h0, 3, 1'b0, 1'b0, 5 + 3);
    // R8: timeout
    iordy = 1'b0;
    run(1'b1, 1'b0, 2'b01, 16'h5A5A, -1, 1'b0, 1'b1, 5 + 6);
    iordy = 1'b1;
    run(1'b0, 1'b0, 2'b10, 16'h0, -1, 1'b0, 1'b0, 5);

    // R9: DMA waits for request
    set_times(2, 3, 2);
    issue(1'b0, 1'b1, 2'b00, 16'h0);
    for (int i = 0; i < 5; i++) begin
      check(dack_n === 1'b1 && dior_n === 1'b1, "R9 no ack without request",
            int'({dack_n, dior_n}), 3);
      @(negedge clk);
    end
    dmarq = 1'b1;
    @(negedge clk);
    // R11: iordy low ignored in DMA
    iordy = 1'b0;
    monitor(1'b0, 1'b1, 2'b00, 16'h0, 16'h4000, 3, -1, 1'b0);
    iordy = 1'b1;
    check(m_pre == 2 && m_act == 3, "R9/R11 DMA timing", m_pre * 100 + m_act, 203);
    check(m_rd == 16'h4003, "R4 DMA read capture", int'(m_rd), 16'h4003);
    // R10: parked with ack held
    check(dack_n === 1'b0, "R10 ack held while request high", int'(dack_n), 0);
    run(1'b1, 1'b1, 2'b00, 16'hBEEF, -1, 1'b0, 1'b0, 3);
    check(dack_n === 1'b0, "R10 ack still held", int'(dack_n), 0);
    dmarq = 1'b0;
    @(negedge clk);
    check(dack_n === 1'b1, "R10 ack released from park", int'(dack_n), 1);
    // R10: request drops during recovery
    dmarq = 1'b1;
    issue(1'b0, 1'b1, 2'b00, 16'h0);
    monitor(1'b0, 1'b1, 2'b00, 16'h0, 16'h7000, 3, -1, 1'b1);
    check(dack_n === 1'b1, "R10 ack released with done", int'(dack_n), 1);
    @(negedge clk);

    // random mix
    for (int n = 0; n < 150; n++) begin
      bit wr = 1'($urandom);
      bit dma = 1'($urandom);
      bit stall = !dma && ($urandom_range(0, 3) == 0);
      int w = $urandom_range(1, 4);
      set_times($urandom_range(0, 6), $urandom_range(0, 6), $urandom_range(0, 6));
      cfg_timeout = 8'($urandom_range(5, 9));
      if (dma) dmarq = 1'b1;
      else if (dmarq) begin dmarq = 1'b0; @(negedge clk); end
      iordy = stall ? 1'b0 : 1'b1;
      run(wr, dma, 2'($urandom_range(1, 2)), 16'($urandom), stall ? w : -1, 1'b0, 1'b0,
          eff(cfg_active) + (stall ? w : 0));
      iordy = 1'b1;
    end
    dmarq = 1'b0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule